// File: doc/BRIEF.md
# Time-over-threshold hit encoder with neighbour-aware zero suppression

The block sits behind the discriminators of a group of eight silicon strip channels. Each channel delivers two asynchronous comparator levels: a low-threshold readout level whose high time carries the pulse amplitude, and a high-threshold level that marks a genuine hit. Both levels are synchronized and sampled once per coarse period of `N_CH` fast clocks, which is one timestamp unit. A single processing path visits the channels in turn, one per fast clock, and turns low-level transitions into leading-edge and trailing-edge records.

A leading edge stays pending until the high level fires on the same strip or on a directly adjacent strip while the low level is still up. It is then committed and written with the timestamp of its own rising sample. Pulses that are never confirmed are dropped, but the strips next to a confirmed hit keep their data, so a cluster centroid can still be formed downstream. Records go into a local first-word-fall-through FIFO. The FIFO drops records when it is full and raises a sticky flag. A spill-start strobe restarts the timestamp and clears the flag.

Top module: `tot_hit_encoder`

## Requirements
- R1: After reset the FIFO is empty, `full_o` is 0 and `overflow_o` is 0.
- R2: A low-level pulse is discarded and writes no record when, during all of its samples, no high level is seen on its own strip or on an adjacent strip.
- R3: A confirmed pulse writes exactly two records. The leading record carries the timestamp of the sample in which the low level was first seen high. The trailing record carries the timestamp of the first sample in which it was seen low again.
- R4: When confirmation comes in a sample after the rise, the leading record is written at that later sample and still carries the timestamp of the rising sample.
- R5: A high level on strip k-1 or strip k+1 confirms a pending pulse on strip k.
- R6: Strips 0 and N_CH-1 are not neighbours of each other. A missing outer neighbour never confirms.
- R7: Once its leading record is written, a pulse always writes its trailing record, even when the high level has dropped.
- R8: A high level seen in the same sample in which the low level is already back low does not confirm, and the pending edge is discarded.
- R9: A record is `{channel[CH_W-1:0], edge, ts[TS_W-1:0]}` from MSB to LSB, with edge 0 = leading and 1 = trailing. With defaults, the channel is in bits 13:11, the edge in bit 10 and the timestamp in bits 9:0. Records produced by one sample enter the FIFO in ascending channel order.
- R10: A record that arrives while the FIFO holds `DEPTH` entries is dropped, and `overflow_o` is set and stays set. `full_o` is 1 exactly when `DEPTH` entries are held.
- R11: A one-cycle `spill_start_i` clears `overflow_o`. It also makes the next sample carry timestamp 0.
- R12: While `empty_o` is 0, `rd_data_o` shows the oldest record, and `rd_en_i` removes it. Records leave in write order.
- R13: The sample timestamp increases by one every `N_CH` fast clocks and wraps modulo 2^TS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast scan clock, N_CH cycles per sampling period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spill_start_i | input | 1 | Restart timestamp and clear overflow flag |
| lo_cmp_i | input | N_CH | Asynchronous low-threshold comparator levels |
| hi_cmp_i | input | N_CH | Asynchronous high-threshold comparator levels |
| rd_en_i | input | 1 | Pop the head record |
| rd_data_o | output | CH_W+1+TS_W | Head record of the FIFO |
| empty_o | output | 1 | FIFO holds no record |
| full_o | output | 1 | FIFO holds DEPTH records |
| overflow_o | output | 1 | Sticky: a record was dropped |

## Verification
The hardest case to reach is a pending edge that is confirmed several samples after its rise, in the same sample in which other channels produce records. The commit must then carry the stored rise timestamp and must still take its place in channel order. Another hard case is a neighbour high level that arrives only in the sample where the low level has already fallen. Directed sequences of per-period level patterns build these cases deliberately. Seeded random bursts, in which levels persist from period to period and high levels are sparse, reach overlapping clusters, chains of pending strips and FIFO overflow. A bench model that follows the requirements predicts every record and its timestamp.

// File: rtl/tot_pkg.sv
package tot_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_PEND = 2'd1,
    CH_ACT  = 2'd2
  } ch_state_e;

  localparam logic EDGE_LEAD  = 1'b0;
  localparam logic EDGE_TRAIL = 1'b1;
endpackage

// File: rtl/tot_sampler.sv
module tot_sampler #(
  parameter int N_CH = 8,
  parameter int TS_W = 10,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            spill_i,
  input  logic [N_CH-1:0] lo_i,
  input  logic [N_CH-1:0] hi_i,
  output logic [CH_W-1:0] slot_o,
  output logic [N_CH-1:0] lo_cur_o,
  output logic [N_CH-1:0] lo_prev_o,
  output logic [N_CH-1:0] hi_cur_o,
  output logic [TS_W-1:0] ts_o
);
  logic [N_CH-1:0] lo_s2, hi_s2;
  logic [CH_W-1:0] slot_q;
  logic [TS_W-1:0] ts_cnt_q;
  logic            last_slot;

  for (genvar k = 0; k < N_CH; k++) begin : g_sync
    logic [1:0] lo_ff, hi_ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_ff <= '0;
        hi_ff <= '0;
      end else begin
        lo_ff <= {lo_ff[0], lo_i[k]};
        hi_ff <= {hi_ff[0], hi_i[k]};
      end
    end
    assign lo_s2[k] = lo_ff[1];
    assign hi_s2[k] = hi_ff[1];
  end

  assign last_slot = (slot_q == CH_W'(N_CH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else if (last_slot) slot_q <= '0;
    else slot_q <= slot_q + 1'b1;
  end

  // snapshot taken at the end of a period; stable through the next scan
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cur_o  <= '0;
      lo_prev_o <= '0;
      hi_cur_o  <= '0;
      ts_o      <= '0;
      ts_cnt_q  <= '0;
    end else begin
      if (last_slot) begin
        lo_prev_o <= lo_cur_o;
        lo_cur_o  <= lo_s2;
        hi_cur_o  <= hi_s2;
        ts_o      <= ts_cnt_q;
      end
      if (spill_i) ts_cnt_q <= '0;
      else if (last_slot) ts_cnt_q <= ts_cnt_q + 1'b1;
    end
  end

  assign slot_o = slot_q;

  a_r13_slot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_slot |=> (slot_q == '0));
  a_r13_ts_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_slot && !spill_i) |=> (ts_cnt_q == $past(ts_cnt_q) + 1'b1) && (ts_o == $past(ts_cnt_q)));
  a_r11_spill_ts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_i |=> (ts_cnt_q == '0));
endmodule

// File: rtl/tot_scan.sv
module tot_scan
  import tot_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int TS_W = 10,
  localparam int CH_W = $clog2(N_CH),
  localparam int REC_W = CH_W + 1 + TS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_W-1:0]  slot_i,
  input  logic [N_CH-1:0]  lo_cur_i,
  input  logic [N_CH-1:0]  lo_prev_i,
  input  logic [N_CH-1:0]  hi_cur_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic             wr_o,
  output logic [REC_W-1:0] wr_data_o
);
  ch_state_e       st_q    [N_CH];
  logic [TS_W-1:0] lts_q   [N_CH];
  ch_state_e       st_nxt;
  logic [TS_W-1:0] lts_nxt;
  logic [TS_W-1:0] rec_ts;
  logic            rec_edge;
  logic            lo_c, lo_p, vld;
  logic [N_CH+1:0] hi_ext;

  // outer neighbours of strips 0 and N_CH-1 padded with zero
  assign hi_ext = {1'b0, hi_cur_i, 1'b0};
  assign vld    = |hi_ext[slot_i +: 3];
  assign lo_c   = lo_cur_i[slot_i];
  assign lo_p   = lo_prev_i[slot_i];

  always_comb begin
    st_nxt   = st_q[slot_i];
    lts_nxt  = lts_q[slot_i];
    wr_o     = 1'b0;
    rec_edge = EDGE_LEAD;
    rec_ts   = ts_i;
    unique case (st_q[slot_i])
      CH_IDLE: if (lo_c && !lo_p) begin
        if (vld) begin
          wr_o   = 1'b1;
          st_nxt = CH_ACT;
        end else begin
          st_nxt  = CH_PEND;
          lts_nxt = ts_i;
        end
      end
      CH_PEND: if (!lo_c) begin
        st_nxt = CH_IDLE;
      end else if (vld) begin
        wr_o   = 1'b1;
        rec_ts = lts_q[slot_i];
        st_nxt = CH_ACT;
      end
      CH_ACT: if (!lo_c && lo_p) begin
        wr_o     = 1'b1;
        rec_edge = EDGE_TRAIL;
        st_nxt   = CH_IDLE;
      end
      default: st_nxt = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_CH; k++) begin
        st_q[k]  <= CH_IDLE;
        lts_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < N_CH; k++) begin
        if (slot_i == CH_W'(k)) begin
          st_q[k]  <= st_nxt;
          lts_q[k] <= lts_nxt;
        end
      end
    end
  end

  assign wr_data_o = {slot_i, rec_edge, rec_ts};

  a_r8_trail_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && wr_data_o[TS_W] == EDGE_TRAIL) |-> (!lo_cur_i[slot_i] && lo_prev_i[slot_i]));
  a_r2_lead_confirmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && wr_data_o[TS_W] == EDGE_LEAD) |-> (lo_cur_i[slot_i] && (hi_ext[slot_i +: 3] != '0)));
endmodule

// File: rtl/tot_fifo.sv
module tot_fifo #(
  parameter int W     = 14,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         spill_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  logic [W-1:0]   mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [PTR_W:0]   count_q;
  logic           wr_ok, rd_ok;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == (PTR_W+1)'(DEPTH));
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (wr_ok) wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_ok) rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      count_q <= count_q + (PTR_W+1)'(wr_ok) - (PTR_W+1)'(rd_ok);
      if (spill_i) ovf_o <= 1'b0;
      else if (wr_i && full_o) ovf_o <= 1'b1;
    end
  end

  a_r10_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i) |=> (count_q == $past(count_q)) && ovf_o);
  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !spill_i) |=> ovf_o);
  a_r11_spill_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_i |=> !ovf_o);
  a_r12_pop_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_o && !wr_i) |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/tot_hit_encoder.sv
module tot_hit_encoder #(
  parameter int N_CH  = 8,
  parameter int TS_W  = 10,
  parameter int DEPTH = 16,
  localparam int CH_W  = $clog2(N_CH),
  localparam int REC_W = CH_W + 1 + TS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spill_start_i,
  input  logic [N_CH-1:0]  lo_cmp_i,
  input  logic [N_CH-1:0]  hi_cmp_i,
  input  logic             rd_en_i,
  output logic [REC_W-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             overflow_o
);
  logic [CH_W-1:0]  slot;
  logic [N_CH-1:0]  lo_cur, lo_prev, hi_cur;
  logic [TS_W-1:0]  ts;
  logic             wr;
  logic [REC_W-1:0] wr_data;

  tot_sampler #(.N_CH(N_CH), .TS_W(TS_W)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .spill_i   (spill_start_i),
    .lo_i      (lo_cmp_i),
    .hi_i      (hi_cmp_i),
    .slot_o    (slot),
    .lo_cur_o  (lo_cur),
    .lo_prev_o (lo_prev),
    .hi_cur_o  (hi_cur),
    .ts_o      (ts)
  );

  tot_scan #(.N_CH(N_CH), .TS_W(TS_W)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slot_i    (slot),
    .lo_cur_i  (lo_cur),
    .lo_prev_i (lo_prev),
    .hi_cur_i  (hi_cur),
    .ts_i      (ts),
    .wr_o      (wr),
    .wr_data_o (wr_data)
  );

  tot_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .spill_i (spill_start_i),
    .wr_i    (wr),
    .wdata_i (wr_data),
    .rd_i    (rd_en_i),
    .rdata_o (rd_data_o),
    .empty_o (empty_o),
    .full_o  (full_o),
    .ovf_o   (overflow_o)
  );

  a_r1_reset_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> empty_o && !overflow_o);
endmodule

// File: tb/tot_hit_encoder_tb.sv
module tot_hit_encoder_tb;
  localparam int N_CH = 8, TS_W = 10, DEPTH = 16, REC_W = 14;

  logic clk = 1'b0, rst_ni = 1'b0, spill = 1'b0, rd_en = 1'b0;
  logic [N_CH-1:0] lo = '0, hi = '0;
  logic [REC_W-1:0] rd_data;
  logic empty, full, ovf;
  int   total = 0, bad = 0, cyc = 0;
  bit   done = 0;

  // bench model state (IDLE=0, PEND=1, ACT=2)
  int mst [N_CH];
  int mlts[N_CH];
  logic [N_CH-1:0] mprev = '0;
  logic [REC_W-1:0] expq[$];
  bit   movf = 0;
  int   spill_base = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  tot_hit_encoder #(.N_CH(N_CH), .TS_W(TS_W), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .spill_start_i(spill), .lo_cmp_i(lo),
    .hi_cmp_i(hi), .rd_en_i(rd_en), .rd_data_o(rd_data), .empty_o(empty),
    .full_o(full), .overflow_o(ovf));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void push(int ch, bit edge_t, int ts);
    logic [REC_W-1:0] r;
    r = {3'(ch), edge_t, 10'(ts)};
    if (expq.size() >= DEPTH) movf = 1;
    else expq.push_back(r);
  endfunction

  function automatic void model(logic [N_CH-1:0] l, logic [N_CH-1:0] h, int ts);
    for (int k = 0; k < N_CH; k++) begin
      bit v;
      v = h[k] || (k > 0 && h[k-1]) || (k < N_CH-1 && h[k+1]);
      case (mst[k])
        0: if (l[k] && !mprev[k]) begin
             if (v) begin push(k, 0, ts); mst[k] = 2; end
             else begin mst[k] = 1; mlts[k] = ts; end
           end
        1: if (!l[k]) mst[k] = 0;
           else if (v) begin push(k, 0, mlts[k]); mst[k] = 2; end
        default: if (!l[k] && mprev[k]) begin push(k, 1, ts); mst[k] = 0; end
      endcase
    end
    mprev = l;
  endfunction

  // one sampling period; called at a negedge aligned to a period start
  task automatic period(logic [N_CH-1:0] l, logic [N_CH-1:0] h, bit sp = 0);
    int idx;
    idx = cyc / N_CH;
    if (sp) begin spill_base = idx; movf = 0; end
    lo = l; hi = h;
    @(posedge clk); @(negedge clk);
    spill = sp;
    @(posedge clk); @(negedge clk);
    spill = 1'b0;
    repeat (N_CH - 2) @(posedge clk);
    @(negedge clk);
    model(l, h, (idx - spill_base) & ((1 << TS_W) - 1));
  endtask

  task automatic drain(string req);
    period(lo, hi);
    check({req, " full"}, 32'(full), 32'(expq.size() >= DEPTH));
    foreach (expq[i]) begin
      check({req, " nonempty"}, 32'(empty), 0);
      check({req, " record"}, 32'(rd_data), 32'(expq[i]));
      rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
    end
    check({req, " empty"}, 32'(empty), 1);
    check({req, " overflow"}, 32'(ovf), 32'(movf));
    expq.delete();
    while (cyc % N_CH != 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N_CH-1:0] rl, rh;
    void'($urandom(32'd4242));
    foreach (mst[k]) begin mst[k] = 0; mlts[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 empty", 32'(empty), 1);
    check("R1 overflow", 32'(ovf), 0);
    check("R1 full", 32'(full), 0);
    rst_ni = 1'b1;

    // R2: pulse without any high level
    period(8'h08, 8'h00); period(8'h08, 8'h00); period(8'h00, 8'h00);
    drain("R2");
    // R3: confirmed on own strip
    period(8'h04, 8'h04); period(8'h04, 8'h00); period(8'h00, 8'h00);
    drain("R3");
    // R4: late confirmation keeps the rise timestamp
    period(8'h10, 8'h00); period(8'h10, 8'h00); period(8'h10, 8'h10); period(8'h00, 8'h00);
    drain("R4");
    // R5: confirmation from both neighbours
    period(8'h20, 8'h10); period(8'h00, 8'h00);
    period(8'h20, 8'h40); period(8'h00, 8'h00);
    drain("R5");
    // R6: no wrap between strip 0 and strip N_CH-1
    period(8'h01, 8'h80); period(8'h00, 8'h00);
    period(8'h80, 8'h01); period(8'h00, 8'h00);
    drain("R6");
    // R7: trailing record after high level has gone
    period(8'h02, 8'h02); period(8'h02, 8'h00); period(8'h02, 8'h00); period(8'h00, 8'h00);
    drain("R7");
    // R8: high level only in the falling sample
    period(8'h08, 8'h00); period(8'h00, 8'h08); period(8'h00, 8'h00);
    drain("R8");
    // R9: several channels in one sample, ascending order
    period(8'h0F, 8'h02); period(8'h0F, 8'h08); period(8'h00, 8'h00);
    drain("R9");
    // R13: idle periods advance the timestamp
    repeat (5) period(8'h00, 8'h00);
    period(8'h40, 8'h40); period(8'h00, 8'h00);
    drain("R13");
    // R10: overflow
    period(8'hFF, 8'hFF); period(8'h00, 8'h00); period(8'hFF, 8'hFF); period(8'h00, 8'h00);
    drain("R10");
    // R11: spill start clears flag and timestamp
    period(8'h00, 8'h00, 1);
    check("R11 overflow cleared", 32'(ovf), 0);
    period(8'h04, 8'h04); period(8'h00, 8'h00);
    drain("R11");

    // R12: seeded random bursts
    for (int b = 0; b < 30; b++) begin
      int n;
      n = 3 + int'($urandom % 6);
      for (int p = 0; p < n; p++) begin
        rl = lo ^ (N_CH'($urandom) & N_CH'($urandom));
        rh = N_CH'($urandom) & N_CH'($urandom) & N_CH'($urandom);
        period(rl, rh);
      end
      period(8'h00, 8'h00);
      drain("R12");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule